// File: doc/BRIEF.md
# Next-PC Unit for Branch, Call and Jump-and-Link

This block holds the program counter of a small 32-bit load/store processor. It decides the address of the following instruction and produces the return-address write for subroutine linkage. In each clock cycle it takes the instruction word at the current PC, the four condition flags from the status register and a jump target that the execute stage has already computed. On the next rising edge it moves the PC to that instruction's successor.

Conditional and unconditional branches and calls use PC-relative word displacements. A jump-and-link goes to the absolute target supplied by the execute stage. Calls and jumps expose a register-file write port. That port carries the address of the transferring instruction itself, not the instruction after it. A write aimed at register 0 is dropped, because register 0 always reads as zero. A jump to a target that is not word-aligned raises a flag and leaves the PC where it was. There are no delay slots, no pipelining and no exceptions.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC loads `RESET_PC` (default 2048, 0x800).
- R2: Any instruction that is not a branch, call or jump-and-link advances the PC by 4 and requests no link write. This covers op (bits 31:30) = 11, op = 10 with op3 (bits 24:19) other than 111000, and op = 00 with op2 (bits 24:22) other than 010. The condition flags and the jump target have no effect on these instructions.
- R3: A branch is op = 00, op2 = 010, with cond in bits 28:25 and a 22-bit signed displacement in bits 21:0. The flag input is `cc_i` = {n, z, v, c}, with n at bit 3 and c at bit 0. The tested flag is z for cond 0001, c for 0101, n for 0110 and v for 0111. When the tested flag is 1, the new PC is PC + 4 × sign-extended displacement, modulo 2^32.
- R4: A branch whose tested flag is 0 advances the PC by 4. The same holds for a branch whose cond is none of 0001, 0101, 0110, 0111 or 1000.
- R5: A branch with cond 1000 is taken whatever the flags are.
- R6: A call is op = 01. It sets the PC to PC + 4 × the signed 30-bit displacement in bits 29:0, wrapping modulo 2^32.
- R7: While a call is presented, `link_we_o` = 1, `link_rd_o` = 15 and `link_val_o` = the current PC.
- R8: A jump-and-link is op = 10, op3 = 111000. With an aligned target it loads `jmp_tgt_i` into the PC. It requests a link write of the current PC to the register in bits 29:25.
- R9: A link whose destination register is 0 is never requested (`link_we_o` = 0).
- R10: A jump-and-link whose target has either of bits 1:0 set drives `misalign_o` = 1, requests no link write and leaves the PC unchanged. `misalign_o` is 0 for every other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word at the current PC |
| cc_i | input | 4 | Condition flags {n, z, v, c} |
| jmp_tgt_i | input | XLEN | Jump target (rs1 + second operand) from the execute stage |
| pc_o | output | XLEN | Current program counter |
| link_we_o | output | 1 | Link register write request |
| link_rd_o | output | 5 | Link destination register number |
| link_val_o | output | XLEN | Link value (address of the transferring instruction) |
| misalign_o | output | 1 | Jump target not word-aligned |

## Verification
The bench uses the default parameters: XLEN = 32, RESET_PC = 0x800 and link register 15. At these values the displacement sign extension reaches exactly the 32-bit width, so the zero-width branch of the extension generate is the one elaborated. A call with a large negative displacement from 0x800 therefore wraps the PC onto address 0. A backward branch-always from 0 then wraps to 0xFFFFFFFC. Together these two cases exercise modular target arithmetic at both ends of the address space.

// File: rtl/npc_pkg.sv
// Shared encodings for the next-PC unit.
// Assumes the fixed 32-bit instruction word layout; field positions are
// decoded by neighbouring logic and must not move.
package npc_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned REG_AW  = 5;

    // Major opcode (bits 31:30)
    localparam logic [1:0] OP_FMT0  = 2'b00;
    localparam logic [1:0] OP_CALL  = 2'b01;
    localparam logic [1:0] OP_ARITH = 2'b10;

    // Sub-opcodes
    localparam logic [2:0] OP2_BRANCH = 3'b010;
    localparam logic [5:0] OP3_JMPL   = 6'b111000;

    // Branch condition selectors
    localparam logic [3:0] BC_ZERO   = 4'b0001;
    localparam logic [3:0] BC_CARRY  = 4'b0101;
    localparam logic [3:0] BC_NEG    = 4'b0110;
    localparam logic [3:0] BC_OVF    = 4'b0111;
    localparam logic [3:0] BC_ALWAYS = 4'b1000;

    // Flag positions inside the {n,z,v,c} bundle
    localparam int unsigned CC_N = 3;
    localparam int unsigned CC_Z = 2;
    localparam int unsigned CC_V = 1;
    localparam int unsigned CC_C = 0;

    typedef enum logic [1:0] {
        XFER_SEQ    = 2'd0,
        XFER_BRANCH = 2'd1,
        XFER_CALL   = 2'd2,
        XFER_JUMP   = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/npc_decode.sv
// Instruction classifier for control transfers.
// Produces the transfer kind, the branch condition, the destination register
// field and the byte offset (already scaled by 4) for PC-relative targets.
// Assumes XLEN >= 32.
module npc_decode
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [INSTR_W-1:0] instr_i,
    output xfer_kind_e         kind_o,
    output logic [3:0]         cond_o,
    output logic [REG_AW-1:0]  rd_o,
    output logic [XLEN-1:0]    offset_o
);

    localparam int unsigned BR_EXT   = XLEN - 24;
    localparam int unsigned CALL_EXT = XLEN - 32;

    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] call_off;

    // Classify the instruction by op, op2 and op3
    always_comb begin
        kind_o = XFER_SEQ;
        unique case (instr_i[31:30])
            OP_FMT0:  if (instr_i[24:22] == OP2_BRANCH) kind_o = XFER_BRANCH;
            OP_CALL:  kind_o = XFER_CALL;
            OP_ARITH: if (instr_i[24:19] == OP3_JMPL)   kind_o = XFER_JUMP;
            default:  kind_o = XFER_SEQ;
        endcase
    end

    assign cond_o = instr_i[28:25];
    assign rd_o   = instr_i[29:25];

    // 22-bit word displacement, sign-extended and scaled
    assign br_off = {{BR_EXT{instr_i[21]}}, instr_i[21:0], 2'b00};

    // 30-bit word displacement: extension width depends on XLEN
    generate
        if (CALL_EXT > 0) begin : g_call_wide
            assign call_off = {{CALL_EXT{instr_i[29]}}, instr_i[29:0], 2'b00};
        end else begin : g_call_exact
            assign call_off = {instr_i[29:0], 2'b00};
        end
    endgenerate

    // Select the offset matching the transfer kind
    always_comb begin
        offset_o = br_off;
        if (instr_i[31:30] == OP_CALL) offset_o = call_off;
    end

endmodule

// File: rtl/npc_cond_eval.sv
// Branch condition evaluator.
// Maps the 4-bit cond field and the {n,z,v,c} flags to a taken decision.
// Unlisted cond codes are never taken.
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] cc_i,
    output logic       take_o
);

    // Pick the flag tested by the condition code
    always_comb begin
        unique case (cond_i)
            BC_ZERO:   take_o = cc_i[CC_Z];
            BC_CARRY:  take_o = cc_i[CC_C];
            BC_NEG:    take_o = cc_i[CC_N];
            BC_OVF:    take_o = cc_i[CC_V];
            BC_ALWAYS: take_o = 1'b1;
            default:   take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Next-address selector.
// Chooses between sequential, PC-relative and absolute targets and detects
// jump targets that are not word-aligned (PC then holds its value).
// Arithmetic wraps modulo 2^XLEN.
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  xfer_kind_e      kind_i,
    input  logic            take_i,
    input  logic [XLEN-1:0] offset_i,
    input  logic [XLEN-1:0] jmp_tgt_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            misalign_o
);

    localparam int unsigned ALIGN_BITS = 2;
    localparam logic [XLEN-1:0] STEP   = XLEN'(4);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;

    assign seq_pc = pc_i + STEP;
    assign rel_pc = pc_i + offset_i;

    // Select the successor address for the current transfer kind
    always_comb begin
        next_pc_o  = seq_pc;
        misalign_o = 1'b0;
        unique case (kind_i)
            XFER_BRANCH: if (take_i) next_pc_o = rel_pc;
            XFER_CALL:   next_pc_o = rel_pc;
            XFER_JUMP: begin
                if (|jmp_tgt_i[ALIGN_BITS-1:0]) begin
                    misalign_o = 1'b1;
                    next_pc_o  = pc_i;
                end else begin
                    next_pc_o  = jmp_tgt_i;
                end
            end
            default: next_pc_o = seq_pc;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
// Next-PC unit: PC register plus link-write generation.
// One instruction is consumed per clock; the PC moves on every rising edge
// out of reset. Link outputs are combinational for the presented instruction.
// Assumes the register file ignores writes when link_we_o is low.
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned       XLEN     = 32,
    parameter logic [XLEN-1:0]   RESET_PC = XLEN'(2048),
    parameter logic [REG_AW-1:0] LINK_REG = 5'd15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [3:0]          cc_i,
    input  logic [XLEN-1:0]     jmp_tgt_i,
    output logic [XLEN-1:0]     pc_o,
    output logic                link_we_o,
    output logic [REG_AW-1:0]   link_rd_o,
    output logic [XLEN-1:0]     link_val_o,
    output logic                misalign_o
);

    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   next_pc;
    xfer_kind_e        kind;
    logic [3:0]        cond;
    logic [REG_AW-1:0] rd_field;
    logic [XLEN-1:0]   offset;
    logic              take;
    logic              misalign;

    npc_decode #(.XLEN(XLEN)) decode_i (
        .instr_i  (instr_i),
        .kind_o   (kind),
        .cond_o   (cond),
        .rd_o     (rd_field),
        .offset_o (offset)
    );

    npc_cond_eval cond_i (
        .cond_i (cond),
        .cc_i   (cc_i),
        .take_o (take)
    );

    npc_target #(.XLEN(XLEN)) target_i (
        .pc_i       (pc_q),
        .kind_i     (kind),
        .take_i     (take),
        .offset_i   (offset),
        .jmp_tgt_i  (jmp_tgt_i),
        .next_pc_o  (next_pc),
        .misalign_o (misalign)
    );

    // Program counter register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc;
    end

    // Link request: calls use the fixed link register, jumps use rd
    always_comb begin
        link_rd_o = rd_field;
        link_we_o = 1'b0;
        if (kind == XFER_CALL) begin
            link_rd_o = LINK_REG;
            link_we_o = (LINK_REG != '0);
        end else if (kind == XFER_JUMP) begin
            link_we_o = !misalign && (rd_field != '0);
        end
    end

    assign link_val_o = pc_q;
    assign pc_o       = pc_q;
    assign misalign_o = misalign;

    // R2
    mem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:30] == 2'b11) |=> (pc_o == $past(pc_o) + XLEN'(4)));

    // R7
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:30] == OP_CALL) |->
            (link_we_o && link_rd_o == LINK_REG && link_val_o == pc_o));

    // R9
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_rd_o != '0));

    // R10
    misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |=> (pc_o == $past(pc_o)));

    // R10
    misalign_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> !link_we_o);

    // R10
    pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);

endmodule

// File: tb/npc_unit_tb.sv
// Self-checking bench for npc_unit: a vector table walked in order, then
// directed reset and wrap-around cases.
module npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic [3:0]  cc;
    logic [31:0] tgt;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_rd;
    logic [31:0] link_val;
    logic        misalign;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    npc_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_i    (instr),
        .cc_i       (cc),
        .jmp_tgt_i  (tgt),
        .pc_o       (pc),
        .link_we_o  (link_we),
        .link_rd_o  (link_rd),
        .link_val_o (link_val),
        .misalign_o (misalign)
    );

    // Entry: {req, instr, cc, tgt, exp_pc, exp_we, exp_rd, exp_mis}
    localparam int NV = 17;
    localparam logic [110:0] VEC [NV] = '{
        // R3 be taken (z=1), +5 words
        {4'd3, 2'b00,1'b0,4'b0001,3'b010,22'd5,         4'b0100, 32'h0,   32'h814,  1'b0,5'd0, 1'b0},
        // R4 be not taken
        {4'd4, 2'b00,1'b0,4'b0001,3'b010,22'd5,         4'b0000, 32'h0,   32'h818,  1'b0,5'd0, 1'b0},
        // R3 bcs taken (c=1), +3 words
        {4'd3, 2'b00,1'b0,4'b0101,3'b010,22'd3,         4'b0001, 32'h0,   32'h824,  1'b0,5'd0, 1'b0},
        // R3 bneg taken (n=1), -2 words
        {4'd3, 2'b00,1'b0,4'b0110,3'b010,22'h3FFFFE,    4'b1000, 32'h0,   32'h81C,  1'b0,5'd0, 1'b0},
        // R3 bvs taken (v=1), +4 words
        {4'd3, 2'b00,1'b0,4'b0111,3'b010,22'd4,         4'b0010, 32'h0,   32'h82C,  1'b0,5'd0, 1'b0},
        // R4 bvs not taken, other flags set
        {4'd4, 2'b00,1'b0,4'b0111,3'b010,22'd4,         4'b1101, 32'h0,   32'h830,  1'b0,5'd0, 1'b0},
        // R5 ba with all flags clear
        {4'd5, 2'b00,1'b0,4'b1000,3'b010,22'd2,         4'b0000, 32'h0,   32'h838,  1'b0,5'd0, 1'b0},
        // R4 unlisted cond 0000, all flags set
        {4'd4, 2'b00,1'b0,4'b0000,3'b010,22'd7,         4'b1111, 32'h0,   32'h83C,  1'b0,5'd0, 1'b0},
        // R6 R7 call +25 words
        {4'd6, 2'b01,30'd25,                            4'b0000, 32'h0,   32'h8A0,  1'b1,5'd15,1'b0},
        // R7 call -8 words
        {4'd7, 2'b01,30'h3FFFFFF8,                      4'b0000, 32'h0,   32'h880,  1'b1,5'd15,1'b0},
        // R8 jmpl rd=15 to 0x1000
        {4'd8, 2'b10,5'd15,6'b111000,19'd0,             4'b0000, 32'h1000,32'h1000, 1'b1,5'd15,1'b0},
        // R9 jmpl rd=0 to 0x900
        {4'd9, 2'b10,5'd0,6'b111000,19'd0,              4'b0000, 32'h900, 32'h900,  1'b0,5'd0, 1'b0},
        // R10 jmpl to misaligned 0x902
        {4'd10,2'b10,5'd5,6'b111000,19'd0,              4'b0000, 32'h902, 32'h900,  1'b0,5'd0, 1'b1},
        // R2 arithmetic op, odd target and flags ignored
        {4'd2, 2'b10,5'd3,6'b010000,19'd0,              4'b1111, 32'h123, 32'h904,  1'b0,5'd0, 1'b0},
        // R2 memory op
        {4'd2, 2'b11,5'd1,6'b000000,19'd0,              4'b1111, 32'h0,   32'h908,  1'b0,5'd0, 1'b0},
        // R2 sethi
        {4'd2, 2'b00,5'd1,3'b100,22'h304F15,            4'b1111, 32'h0,   32'h90C,  1'b0,5'd0, 1'b0},
        // R2 format-0 with op2 000
        {4'd2, 2'b00,5'd0,3'b000,22'd9,                 4'b1111, 32'h0,   32'h910,  1'b0,5'd0, 1'b0}
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one instruction, check link outputs, clock it, check the PC
    task automatic step(input int req, input logic [31:0] i_w, input logic [3:0] c_w,
                        input logic [31:0] t_w, input logic [31:0] exp_pc,
                        input bit exp_we, input logic [4:0] exp_rd, input bit exp_mis,
                        input logic [31:0] cur_pc);
        instr = i_w; cc = c_w; tgt = t_w;
        #1;
        chk(link_we == exp_we, req, "link_we", {31'd0, link_we}, {31'd0, exp_we});
        chk(misalign == exp_mis, req, "misalign", {31'd0, misalign}, {31'd0, exp_mis});
        if (exp_we) begin
            chk(link_rd == exp_rd, req, "link_rd", {27'd0, link_rd}, {27'd0, exp_rd});
            chk(link_val == cur_pc, req, "link_val", link_val, cur_pc);
        end
        @(posedge clk); #1;
        chk(pc == exp_pc, req, "pc", pc, exp_pc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] cur;
        rst_n = 1'b0; instr = '0; cc = '0; tgt = '0;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        chk(pc == 32'h800, 1, "reset pc", pc, 32'h800);
        rst_n = 1'b1;
        cur = 32'h800;

        for (int k = 0; k < NV; k++) begin
            logic [110:0] v;
            v = VEC[k];
            step(int'(v[110:107]), v[106:75], v[74:71], v[70:39], v[38:7],
                 v[6], v[5:1], v[0], cur);
            cur = v[38:7];
        end

        // R1 mid-run reset returns to 0x800
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk(pc == 32'h800, 1, "reset pc mid-run", pc, 32'h800);
        rst_n = 1'b1;

        // R6 call -512 words from 0x800 wraps onto 0
        step(6, {2'b01, 30'h3FFFFE00}, 4'b0000, 32'h0, 32'h0, 1'b1, 5'd15, 1'b0, 32'h800);
        // R10 misaligned jump at address 0 holds the PC
        step(10, {2'b10, 5'd4, 6'b111000, 19'd0}, 4'b0000, 32'h3, 32'h0, 1'b0, 5'd0, 1'b1, 32'h0);
        // R5 branch always -1 word from 0 wraps to the top
        step(5, {2'b00, 1'b0, 4'b1000, 3'b010, 22'h3FFFFF}, 4'b0000, 32'h0, 32'hFFFFFFFC,
             1'b0, 5'd0, 1'b0, 32'h0);
        // R8 aligned jump back with link into r31
        step(8, {2'b10, 5'd31, 6'b111000, 19'd0}, 4'b0000, 32'h2000, 32'h2000,
             1'b1, 5'd31, 1'b0, 32'hFFFFFFFC);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule